// File: doc/BRIEF.md
# Flash ECC Event Capture Registers

This block sits beside a flash memory controller and keeps a record of the most recent error-correction event that software has chosen to watch. The controller presents an event strobe together with the event type (single-bit correction or non-correctable error) and the details of the faulting bus access: address, bus master number, master attributes and the 64-bit data word. If the enable bit for that event type is set, the block loads all of these details in one clock edge and raises the status flag for that type.

Software reaches the block through a byte-wide register port with a combinational read path. It writes a configuration byte that holds the two per-type enables, reads and clears the two status flags with write-one-to-clear, and reads the captured details back one byte at a time. The captured values are read-only. A build-time parameter can leave the capture store out. Any access to the capture addresses then ends with a bus error response.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset the configuration byte (address 0x43), the status byte (address 0x47) and every captured byte read as zero.
- R2: With configuration bit 1 set, an event with `ev_corrected`=1 loads the captured fields on the next clock edge and sets status bit 1. The address reads at 0x50..0x53 and the data at 0x58..0x5F, most significant byte first in both cases. The attributes read at 0x57.
- R3: With configuration bit 0 set, an event with `ev_corrected`=0 loads the captured fields and sets status bit 0.
- R4: An event whose type enable is clear changes neither the captured fields nor the status flags.
- R5: A later enabled event overwrites the fields left by an earlier one, so the registers always show the last enabled event.
- R6: The byte at address 0x56 holds the 4-bit master number in bits 3:0. Bits 7:4 always read as zero.
- R7: A write to any capture address (0x50..0x5F) leaves the captured values unchanged and gets no error response when the capture store is present.
- R8: Writing the status byte clears each flag whose bit is written as one. A flag whose bit is written as zero keeps its value.
- R9: If an enabled event arrives in the same cycle as a write that clears its flag, the flag stays set and the fields take the new event's values.
- R10: With `HAS_CAPTURE`=0, any access to 0x50..0x5F asserts `reg_err` and reads zero. Accesses to the configuration and status bytes never assert `reg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | ECC event strobe from the flash controller, one cycle per event |
| ev_corrected | input | 1 | Event type: 1 = single-bit corrected, 0 = non-correctable |
| ev_addr | input | ADDR_W | Faulting access address |
| ev_master | input | MASTER_W | Bus master number of the faulting access |
| ev_attr | input | ATTR_W | Master attributes of the faulting access |
| ev_data | input | DATA_W | Data word of the faulting access |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| reg_err | output | 1 | Bus error response for the current access |

## Verification
The assertions assume that `ev_valid` is a single-cycle strobe with its fields held stable alongside it. They also assume that a register access lasts exactly one cycle with the address and write data settled during that cycle. The bench drives every strobe and field on the falling clock edge and lifts it on the next falling edge. Each event and each access therefore spans exactly one rising edge. The only deliberate overlap of an event with a status write is the collision case of R9.

// File: rtl/ecc_event_capture.sv
module ecc_event_capture #(
  parameter int ADDR_W      = 32,
  parameter int MASTER_W    = 4,
  parameter int ATTR_W      = 8,
  parameter int DATA_W      = 64,
  parameter bit HAS_CAPTURE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic                ev_corrected,
  input  logic [ADDR_W-1:0]   ev_addr,
  input  logic [MASTER_W-1:0] ev_master,
  input  logic [ATTR_W-1:0]   ev_attr,
  input  logic [DATA_W-1:0]   ev_data,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic                reg_err
);
  localparam logic [7:0] A_CFG  = 8'h43;
  localparam logic [7:0] A_STAT = 8'h47;
  localparam logic [7:0] A_ADDR = 8'h50;
  localparam logic [7:0] A_MST  = 8'h56;
  localparam logic [7:0] A_ATTR = 8'h57;
  localparam logic [7:0] A_DATA = 8'h58;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam logic [7:0] A_LAST = A_DATA + 8'(DATA_BYTES - 1);

  logic [7:0]          cfg_q;
  logic                flag_sb_q, flag_nc_q;
  logic [ADDR_W-1:0]   cap_addr;
  logic [MASTER_W-1:0] cap_master;
  logic [ATTR_W-1:0]   cap_attr;
  logic [DATA_W-1:0]   cap_data;

  wire take_sb = ev_valid &  ev_corrected & cfg_q[1];
  wire take_nc = ev_valid & ~ev_corrected & cfg_q[0];
  wire take    = take_sb | take_nc;
  wire cfg_wr  = reg_sel & reg_wr & (reg_addr == A_CFG);
  wire stat_wr = reg_sel & reg_wr & (reg_addr == A_STAT);
  wire hit_cap = reg_sel & (reg_addr >= A_ADDR) & (reg_addr <= A_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      flag_sb_q <= 1'b0;
      flag_nc_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= reg_wdata;
      flag_sb_q <= take_sb | (flag_sb_q & ~(stat_wr & reg_wdata[1]));
      flag_nc_q <= take_nc | (flag_nc_q & ~(stat_wr & reg_wdata[0]));
    end
  end

  generate
    if (HAS_CAPTURE) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cap_addr   <= '0;
          cap_master <= '0;
          cap_attr   <= '0;
          cap_data   <= '0;
        end else if (take) begin
          cap_addr   <= ev_addr;
          cap_master <= ev_master;
          cap_attr   <= ev_attr;
          cap_data   <= ev_data;
        end
      end

      p_capture_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_sb |=> (cap_master == $past(ev_master)) && (cap_addr == $past(ev_addr)));
      p_capture_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_nc |=> (cap_data == $past(ev_data)) && (cap_attr == $past(ev_attr)));
      p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cap_addr) && $stable(cap_data) && $stable(cap_master));
      p_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cap && reg_wr && !take) |=> $stable(cap_attr) && $stable(cap_master));
      p_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cap |-> !reg_err);
    end else begin : g_nostore
      assign cap_addr   = '0;
      assign cap_master = '0;
      assign cap_attr   = '0;
      assign cap_data   = '0;
      p_err_on_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cap |-> reg_err && (reg_rdata == 8'h00));
    end
  endgenerate

  assign reg_err = hit_cap & ~HAS_CAPTURE;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_sel && !reg_wr && !reg_err) begin
      if (reg_addr == A_CFG)  reg_rdata = cfg_q;
      if (reg_addr == A_STAT) reg_rdata = {6'b0, flag_sb_q, flag_nc_q};
      if (reg_addr == A_MST)  reg_rdata = {{(8-MASTER_W){1'b0}}, cap_master};
      if (reg_addr == A_ATTR) reg_rdata = cap_attr[7:0];
      for (int i = 0; i < ADDR_BYTES; i++)
        if (reg_addr == A_ADDR + 8'(i)) reg_rdata = cap_addr[8*(ADDR_BYTES-1-i) +: 8];
      for (int i = 0; i < DATA_BYTES; i++)
        if (reg_addr == A_DATA + 8'(i)) reg_rdata = cap_data[8*(DATA_BYTES-1-i) +: 8];
    end
  end

  p_flag_sb_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_sb |=> flag_sb_q);
  p_flag_nc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_nc |=> flag_nc_q);
  p_disabled_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_corrected && !cfg_q[1] && !flag_sb_q && !stat_wr) |=> !flag_sb_q);
  p_upper_nibble_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr == A_MST) |-> (reg_rdata[7:4] == 4'h0));
  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[0] && !take_nc) |=> !flag_nc_q);
  p_w0_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !reg_wdata[1] && flag_sb_q) |=> flag_sb_q);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[1] && take_sb) |=> flag_sb_q);
  p_ctrl_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && (reg_addr == A_CFG || reg_addr == A_STAT)) |-> !reg_err);
endmodule

// File: tb/ecc_event_capture_bench.sv
module ecc_event_capture_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        kind;
    logic [1:0]  cfg;
    logic [3:0]  mst;
    logic [7:0]  attr;
    logic [31:0] addr;
    logic [63:0] data;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b1, 2'b11, 4'h3, 8'h5A, 32'h1000_0040, 64'h0123_4567_89AB_CDEF},
    '{1'b0, 2'b11, 4'h7, 8'hC3, 32'h2000_1F08, 64'hFEDC_BA98_7654_3210},
    '{1'b1, 2'b01, 4'h1, 8'h11, 32'hDEAD_0000, 64'h1111_2222_3333_4444},
    '{1'b0, 2'b10, 4'h2, 8'h22, 32'hBEEF_0000, 64'h5555_6666_7777_8888},
    '{1'b0, 2'b01, 4'hE, 8'h81, 32'h0000_FFFC, 64'h8000_0000_0000_0001},
    '{1'b1, 2'b10, 4'hF, 8'hFF, 32'hFFFF_FFF8, 64'hA5A5_5A5A_F00F_0FF0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_corrected = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [3:0]  ev_master = '0;
  logic [7:0]  ev_attr = '0;
  logic [63:0] ev_data = '0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] rdata, rdata_n;
  logic err, err_n;
  int checks = 0, errors = 0;

  logic [31:0] x_addr = '0;
  logic [3:0]  x_mst = '0;
  logic [7:0]  x_attr = '0;
  logic [63:0] x_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_event_capture u_ecc_event_capture (
    .clk, .rst_n, .ev_valid, .ev_corrected, .ev_addr, .ev_master, .ev_attr, .ev_data,
    .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata(rdata), .reg_err(err));

  ecc_event_capture #(.HAS_CAPTURE(1'b0)) u_ecc_event_capture_nocap (
    .clk, .rst_n, .ev_valid, .ev_corrected, .ev_addr, .ev_master, .ev_attr, .ev_data,
    .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata(rdata_n), .reg_err(err_n));

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic drive_ev(logic kind, logic [31:0] a, logic [3:0] m, logic [7:0] at, logic [63:0] d);
    ev_valid = 1'b1; ev_corrected = kind; ev_addr = a; ev_master = m; ev_attr = at; ev_data = d;
  endtask

  task automatic fire(logic kind, logic [31:0] a, logic [3:0] m, logic [7:0] at, logic [63:0] d);
    @(negedge clk);
    drive_ev(kind, a, m, at, d);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic read_all(output logic [31:0] a, output logic [7:0] m,
                          output logic [7:0] at, output logic [63:0] d);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(8'h50 + 8'(i), b); a = {a[23:0], b}; end
    rd(8'h56, m);
    rd(8'h57, at);
    for (int i = 0; i < 8; i++) begin rd(8'h58 + 8'(i), b); d = {d[55:0], b}; end
  endtask

  task automatic check_capture(string req);
    logic [31:0] a; logic [7:0] m, at; logic [63:0] d;
    read_all(a, m, at, d);
    check({req, " addr"}, 128'(a), 128'(x_addr));
    check({req, " master"}, 128'(m), 128'({4'h0, x_mst}));
    check({req, " attr"}, 128'(at), 128'(x_attr));
    check({req, " data"}, 128'(d), 128'(x_data));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic take;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h43, b); check("R1 cfg", 128'(b), 128'h0);
    rd(8'h47, b); check("R1 status", 128'(b), 128'h0);
    check_capture("R1");

    // R2 R3 R4 R5 table walk
    foreach (VECS[i]) begin
      wr(8'h43, {6'b0, VECS[i].cfg});
      wr(8'h47, 8'h03);
      fire(VECS[i].kind, VECS[i].addr, VECS[i].mst, VECS[i].attr, VECS[i].data);
      take = VECS[i].kind ? VECS[i].cfg[1] : VECS[i].cfg[0];
      if (take) begin
        x_addr = VECS[i].addr; x_mst = VECS[i].mst; x_attr = VECS[i].attr; x_data = VECS[i].data;
      end
      rd(8'h47, b);
      check(take ? (VECS[i].kind ? "R2 status" : "R3 status") : "R4 status",
            128'(b), take ? (VECS[i].kind ? 128'h2 : 128'h1) : 128'h0);
      check_capture(take ? (i == 5 ? "R5" : "R2/R3 fields") : "R4 fields");
    end

    // R6 upper nibble zero with master 0xA
    wr(8'h43, 8'h03);
    fire(1'b1, 32'h0000_0100, 4'hA, 8'h44, 64'h99);
    x_addr = 32'h0000_0100; x_mst = 4'hA; x_attr = 8'h44; x_data = 64'h99;
    rd(8'h56, b); check("R6 master byte", 128'(b), 128'h0A);

    // R7 writes to capture addresses ignored
    wr(8'h56, 8'hFF); check("R7 err", 128'(err), 128'h0);
    wr(8'h50, 8'hFF); wr(8'h57, 8'h00); wr(8'h5F, 8'h77);
    check_capture("R7");

    // R8 W1C behaviour
    fire(1'b0, 32'h0000_0200, 4'h5, 8'h55, 64'h1234);
    x_addr = 32'h0000_0200; x_mst = 4'h5; x_attr = 8'h55; x_data = 64'h1234;
    rd(8'h47, b); check("R8 both set", 128'(b), 128'h3);
    wr(8'h47, 8'h00); rd(8'h47, b); check("R8 write zero keeps", 128'(b), 128'h3);
    wr(8'h47, 8'h02); rd(8'h47, b); check("R8 clear bit1 only", 128'(b), 128'h1);
    wr(8'h47, 8'h01); rd(8'h47, b); check("R8 clear bit0", 128'(b), 128'h0);

    // R9 event and clear in the same cycle
    fire(1'b1, 32'h0, 4'h0, 8'h0, 64'h0);
    fire(1'b0, 32'h0, 4'h0, 8'h0, 64'h0);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h47; reg_wdata = 8'h03;
    drive_ev(1'b1, 32'hCAFE_0008, 4'h9, 8'h3C, 64'h0BAD_F00D_0000_0042);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; ev_valid = 1'b0;
    x_addr = 32'hCAFE_0008; x_mst = 4'h9; x_attr = 8'h3C; x_data = 64'h0BAD_F00D_0000_0042;
    rd(8'h47, b); check("R9 event wins", 128'(b), 128'h2);
    check_capture("R9");

    // R10 capture store absent
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 8'h56;
    #1;
    check("R10 err nocap", 128'(err_n), 128'h1);
    check("R10 rdata nocap", 128'(rdata_n), 128'h0);
    check("R10 err present", 128'(err), 128'h0);
    reg_addr = 8'h47;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h5C; reg_wdata = 8'h00;
    #1 check("R10 write err nocap", 128'(err_n), 128'h1);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h43;
    #1 check("R10 cfg no err", 128'(err_n), 128'h0);
    @(negedge clk);
    reg_sel = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule